// File: doc/BRIEF.md
# PHY Management Serial Master

This block runs one complete management transaction to an Ethernet PHY over a two-wire serial link. The link has a clock and a single data line. The data line is open-drain, so the block drives it through a value and an output-enable. The caller supplies a ready-packed 32-bit frame word and a clock-divider setting, then pulses `start`. The block first sends a run of ones as a preamble. It then shifts out the frame header. After the header it does one of two things:
- on a write, it keeps driving the rest of the word;
- on a read, it releases the line and captures 16 data bits from the PHY.

It closes with three idle clock periods, with the line driven high.

The block tells the two kinds of transaction apart by the top nibble of the word. It hands back a 32-bit result:
- on a read, the header merged with the captured data;
- on a write, the word shifted down by 16.

Between transactions both wires rest high and the line is driven. Queuing of commands and the PHY's own behaviour belong to other logic.

Top module: `mgmt_serial_master`

## Requirements
- R1: After reset, and whenever the block is idle: `mdc`=1, `mdio_out`=1, `mdio_oe`=1, `busy`=0. After reset, `done`=0 and `result`=0.
- R2: When the block is idle, a `start` pulse is accepted. `busy` rises at that clock edge and stays high for exactly 134×H system clocks, where H is `half_div`, or 1 if `half_div` is 0. `busy` falls at the same edge at which `done` rises. `done` is high for one cycle only.
- R3: Every bit period is H system clocks with `mdc` low, followed by H system clocks with `mdc` high. The clock falls at the start of each bit and rises in the middle of it.
- R4: The first 32 bit periods carry a driven 1. This is the preamble.
- R5: The next 14 bit periods drive `cmd[31:18]`, most significant bit first.
- R6: A frame is a read when `cmd[31:28]` equals 4'b0110. Any other value is a write.
- R7: On a write, the 18 bit periods after the header drive `cmd[17:0]`, MSB first. `result` becomes `{16'h0000, cmd[31:16]}`.
- R8: On a read, `mdio_oe` is 0 for the 18 bit periods after the header. These are two turnaround periods and then 16 data periods. `mdio_in` is sampled at each rising clock of the 16 data periods, MSB first. `result` becomes `{cmd[31:16], data}`.
- R9: The last 3 bit periods of the 67 drive a 1. The block finishes with `mdc` and `mdio_out` high and `mdio_oe`=1.
- R10: A `start` pulse while `busy` is high is ignored. It changes neither the timing nor the result of the transaction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (ignored while busy) |
| cmd | input | 32 | Packed frame word |
| half_div | input | DIV_W (8) | Clock half-period in system clocks (0 acts as 1) |
| mdio_in | input | 1 | Data line value seen from the pad |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Value driven on the data line |
| mdio_oe | output | 1 | Data line output enable (0 = released) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Transaction result, held until the next completion |

## Verification
The bench replays a table of frame words. The table holds:
- writes;
- reads with different address and register fields;
- a word whose top nibble is close to the read code but not equal to it;
- divider settings of 0 to 4.

Each word is checked three ways: the bit stream captured at every rising clock, the busy length and the returned result. A per-frame check shows whether the data line is driven or released, and when. The PHY model answers reads with patterns that have only the top bit or only the bottom bit set, and with mixed patterns. Comparing the results then exposes shift-direction and off-by-one-sample faults. Directed tests cover the reset state, the zero divider, and a `start` pulse arriving in the middle of a read.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    localparam int PRE_BITS    = 32;
    localparam int CMD_BITS    = 32;
    localparam int HDR_BITS    = 14;
    localparam int DATA_BITS   = 16;
    localparam int TAIL_BITS   = 3;
    localparam int TOTAL_BITS  = PRE_BITS + CMD_BITS + TAIL_BITS;
    localparam int SLOT_W      = $clog2(TOTAL_BITS);
    localparam int RELEASE_LO  = CMD_BITS - HDR_BITS;   // frame bits below this are released on reads
    localparam logic [3:0] RD_OPCODE = 4'b0110;

    typedef enum logic { PH_LOW, PH_HIGH } phase_e;

    typedef struct packed {
        logic data;
        logic oe;
    } pin_drv_t;

    // Frame bit index carried by a slot inside the command region, else -1.
    function automatic int frame_bit(input logic [SLOT_W-1:0] slot);
        int s;
        s = int'(slot);
        if (s >= PRE_BITS && s < PRE_BITS + CMD_BITS)
            return PRE_BITS + CMD_BITS - 1 - s;
        return -1;
    endfunction

    // Line drive for one bit period.
    function automatic pin_drv_t slot_pins(input logic [SLOT_W-1:0] slot,
                                           input logic [CMD_BITS-1:0] cw,
                                           input logic rd);
        pin_drv_t   d;
        int         fb;
        logic [4:0] fi;
        d  = '{data: 1'b1, oe: 1'b1};
        fb = frame_bit(slot);
        if (fb >= 0) begin
            fi     = fb[4:0];
            d.data = cw[fi];
            if (rd && fb < RELEASE_LO) begin
                d.data = 1'b1;
                d.oe   = 1'b0;
            end
        end
        return d;
    endfunction

    // Whether the rising clock of this slot captures a read data bit.
    function automatic logic slot_samples(input logic [SLOT_W-1:0] slot,
                                          input logic rd);
        int fb;
        fb = frame_bit(slot);
        return rd && (fb >= 0) && (fb < DATA_BITS);
    endfunction

endpackage

// File: rtl/mgmt_half_timer.sv
module mgmt_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] eff_in;
    logic [DIV_W-1:0] eff_q;

    assign eff_in = (div == '0) ? DIV_W'(1) : div;
    assign eff_q  = (div_q == '0) ? DIV_W'(1) : div_q;
    assign tick   = run && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cnt   <= '0;
        end else if (load) begin
            div_q <= div;
            cnt   <= eff_in - DIV_W'(1);
        end else if (run) begin
            cnt <= (cnt == '0) ? eff_q - DIV_W'(1) : cnt - DIV_W'(1);
        end
    end
endmodule

// File: rtl/mgmt_slot_seq.sv
module mgmt_slot_seq
    import mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              tick,
    output logic [SLOT_W-1:0] slot,
    output phase_e            phase,
    output logic              last
);
    assign last = (slot == SLOT_W'(TOTAL_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            slot  <= '0;
            phase <= PH_LOW;
        end else if (load) begin
            slot  <= '0;
            phase <= PH_LOW;
        end else if (tick) begin
            if (phase == PH_LOW) begin
                phase <= PH_HIGH;
            end else if (!last) begin
                slot  <= slot + SLOT_W'(1);
                phase <= PH_LOW;
            end
        end
    end
endmodule

// File: rtl/mgmt_serial_master.sv
module mgmt_serial_master
    import mgmt_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [CMD_BITS-1:0] cmd,
    input  logic [DIV_W-1:0]    half_div,
    input  logic                mdio_in,
    output logic                mdc,
    output logic                mdio_out,
    output logic                mdio_oe,
    output logic                busy,
    output logic                done,
    output logic [CMD_BITS-1:0] result
);
    logic                 accept;
    logic                 tick;
    logic [SLOT_W-1:0]    slot;
    phase_e               phase;
    logic                 last;
    logic [CMD_BITS-1:0]  cmd_q;
    logic                 rd_q;
    logic [DATA_BITS-1:0] cap;
    pin_drv_t             first_d;
    pin_drv_t             nxt_d;
    logic                 cur_smp;

    assign accept  = start && !busy;
    assign first_d = slot_pins('0, cmd, cmd[31:28] == RD_OPCODE);
    assign nxt_d   = slot_pins(slot + SLOT_W'(1), cmd_q, rd_q);
    assign cur_smp = slot_samples(slot, rd_q);

    mgmt_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .run  (busy),
        .div  (half_div),
        .tick (tick)
    );

    mgmt_slot_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .tick  (tick),
        .slot  (slot),
        .phase (phase),
        .last  (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            mdc      <= 1'b1;
            mdio_out <= 1'b1;
            mdio_oe  <= 1'b1;
            cmd_q    <= '0;
            rd_q     <= 1'b0;
            cap      <= '0;
            result   <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy     <= 1'b1;
                cmd_q    <= cmd;
                rd_q     <= (cmd[31:28] == RD_OPCODE);
                cap      <= '0;
                mdc      <= 1'b0;
                mdio_out <= first_d.data;
                mdio_oe  <= first_d.oe;
            end else if (busy && tick) begin
                if (phase == PH_LOW) begin
                    mdc <= 1'b1;
                    if (cur_smp)
                        cap <= {cap[DATA_BITS-2:0], mdio_in};
                end else if (last) begin
                    busy   <= 1'b0;
                    done   <= 1'b1;
                    result <= rd_q ? {cmd_q[CMD_BITS-1:DATA_BITS], cap}
                                   : {{DATA_BITS{1'b0}}, cmd_q[CMD_BITS-1:DATA_BITS]};
                end else begin
                    mdc      <= 1'b0;
                    mdio_out <= nxt_d.data;
                    mdio_oe  <= nxt_d.oe;
                end
            end
        end
    end
endmodule

// File: rtl/mgmt_serial_chk.sv
module mgmt_serial_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        mdc,
    input logic        mdio_out,
    input logic        mdio_oe,
    input logic        busy,
    input logic        done,
    input logic [31:0] result
);
    a_r1_idle_lines: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mdc && mdio_out && mdio_oe));

    a_r2_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    a_r2_busy_falls_with_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_result_only_at_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> done);

    a_r8_release_only_busy: assert property (@(posedge clk) disable iff (rst)
        !mdio_oe |-> busy);

    a_r9_ends_high: assert property (@(posedge clk) disable iff (rst)
        done |-> (mdc && mdio_out && mdio_oe));

    a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));
endmodule

bind mgmt_serial_master mgmt_serial_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .mdc      (mdc),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .busy     (busy),
    .done     (done),
    .result   (result)
);

// File: tb/sim_mgmt_serial_master.sv
module sim_mgmt_serial_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] cmd = '0;
    logic [7:0]  half_div = 8'd1;
    logic        mdio_in = 1'b1;
    logic        mdc, mdio_out, mdio_oe, busy, done;
    logic [31:0] result;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // monitor state
    logic [66:0] seen_d, seen_oe;
    int          rise_n, fall_rel, busy_cyc, low_first;
    logic        prev_mdc = 1'b1;
    logic [15:0] phy_word = '0;

    always #2 clk = ~clk;

    mgmt_serial_master u0 (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd), .half_div(half_div),
        .mdio_in(mdio_in), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .busy(busy), .done(done), .result(result)
    );

    // rows: {cmd, phy reply, half_div}
    localparam logic [55:0] VEC [5] = '{
        {32'h50B2_1234, 16'h0000, 8'd1},
        {32'h6186_0000, 16'hA5C3, 8'd2},
        {32'h607E_0000, 16'h0001, 8'd0},
        {32'h7123_ABCD, 16'hFFFF, 8'd3},
        {32'h6FD2_0000, 16'h8000, 8'd4}
    };

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<100000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // PHY model and bit recorder, sampled away from the active edge
    always @(negedge clk) begin
        if (busy) busy_cyc++;
        if (busy && rise_n == 0 && !mdc) low_first++;
        if (!prev_mdc && mdc && rise_n < 67) begin
            seen_d[rise_n]  = mdio_out;
            seen_oe[rise_n] = mdio_oe;
            rise_n++;
        end
        if (mdio_oe) begin
            mdio_in = 1'b1;
        end else if (prev_mdc && !mdc) begin
            fall_rel++;
            mdio_in = (fall_rel > 2) ? phy_word[15 - (fall_rel - 3)] : 1'b0;
        end
        prev_mdc = mdc;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        rise_n = 0; fall_rel = 0; busy_cyc = 0; low_first = 0;
        seen_d = '0; seen_oe = '0;
    endtask

    task automatic wait_done();
        int n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (!done && n < 5000);
    endtask

    task automatic run_vec(input logic [31:0] c, input logic [15:0] p, input logic [7:0] d,
                           input bit interfere);
        int h, pre_bad, hdr_bad, body_bad, tail_bad;
        bit rd;
        logic [31:0] exp_res;
        h  = (d == 0) ? 1 : int'(d);
        rd = (c[31:28] == 4'b0110);                       // R6 read code
        exp_res = rd ? {c[31:16], p} : {16'h0000, c[31:16]};
        @(posedge clk); #1;
        clear_mon();
        phy_word = p; cmd = c; half_div = d; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (interfere) begin
            repeat (30) @(posedge clk);
            #1; cmd = 32'h50B2_1234; half_div = 8'd1; start = 1'b1;   // R10
            @(posedge clk); #1; start = 1'b0;
        end
        wait_done();
        pre_bad = 0; hdr_bad = 0; body_bad = 0; tail_bad = 0;
        for (int k = 0; k < 32; k++)  if (!(seen_oe[k] && seen_d[k])) pre_bad++;
        for (int k = 32; k < 46; k++) if (!(seen_oe[k] && seen_d[k] == c[63-k])) hdr_bad++;
        for (int k = 46; k < 64; k++)
            if (rd ? (seen_oe[k] != 1'b0) : !(seen_oe[k] && seen_d[k] == c[63-k])) body_bad++;
        for (int k = 64; k < 67; k++) if (!(seen_oe[k] && seen_d[k])) tail_bad++;
        check(pre_bad == 0, "R4", "preamble mismatches", pre_bad, 0);
        check(hdr_bad == 0, "R5", "header mismatches", hdr_bad, 0);
        check(body_bad == 0, rd ? "R8" : "R7", "body mismatches", body_bad, 0);
        check(tail_bad == 0, "R9", "trailer mismatches", tail_bad, 0);
        check(rise_n == 67, "R3", "rising clock count", rise_n, 67);
        check(low_first == h, "R3", "first low half length", low_first, h);
        check(busy_cyc == 134*h, interfere ? "R10" : "R2", "busy length", busy_cyc, 134*h);
        check(result == exp_res, interfere ? "R10" : (rd ? "R8" : "R7"), "result", result, exp_res);
        @(posedge clk); #1;
        check(!done && !busy && mdc && mdio_out && mdio_oe, "R9", "idle after finish",
              {27'd0, done, busy, mdc, mdio_out, mdio_oe}, 32'h7);
    endtask

    initial begin
        clear_mon();
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(mdc && mdio_out && mdio_oe && !busy && !done && result == 0, "R1", "reset state",
              {27'd0, mdc, mdio_out, mdio_oe, busy, done}, 32'h1C);
        rst = 1'b0;
        @(posedge clk); #1;
        check(mdc && mdio_out && mdio_oe && !busy, "R1", "idle after reset",
              {28'd0, mdc, mdio_out, mdio_oe, busy}, 32'hE);

        for (int i = 0; i < 5; i++)
            run_vec(VEC[i][55:24], VEC[i][23:8], VEC[i][7:0], 1'b0);

        // R10: start pulse in the middle of a read
        run_vec(32'h6186_0000, 16'h3C5A, 8'd2, 1'b1);

        // R6: nibble 0110 with other bits set still reads
        run_vec(32'h6FFF_FFFF, 16'h1357, 8'd1, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule